// File: doc/BRIEF.md
# Shifted-Operand ALU Execute Unit

This block is the combinational execute stage of a 16-bit processor. It takes a 4-bit operation code, a first operand, a second register operand and a 16-bit immediate. A select bit chooses which form the second input takes. In register form, the second operand goes through a barrel shifter before it reaches the arithmetic logic. A 2-bit kind field and a 4-bit amount field control the shifter. In immediate form, the immediate value goes straight to the arithmetic logic with no shift. The unit has no clock.

The operations are add, subtract, the five bitwise functions (AND, OR, NAND, NOR, XOR), and a set-less-than compare in signed and unsigned versions. The four memory opcodes use the adder to form the load or store address. The unit also drives an equality flag that compares the two raw register operands, for the conditional branches. Memory access, register writeback and program-counter updates take place in other blocks.

Top module: `shifted_alu_exec`

## Requirements
- R1: Opcode 0 gives `src_a + b_eff` and opcode 1 gives `src_a - b_eff`, both taken modulo 2^16. Here `b_eff` means the selected and possibly shifted second operand.
- R2: Opcodes 2 to 6 give the bitwise result of `src_a` and `b_eff` in this order: AND (2), OR (3), NAND (4), NOR (5), XOR (6).
- R3: Opcode 7 gives 16'h0001 when `src_a` is less than `b_eff` as two's-complement numbers, and 16'h0000 otherwise.
- R4: Opcode 8 gives 16'h0001 when `src_a` is less than `b_eff` as unsigned numbers, and 16'h0000 otherwise.
- R5: Opcodes 9, 10, 11 and 12 (the two loads and the two stores) give the address `src_a + b_eff`.
- R6: When `imm_sel` is 1, `b_eff` equals `imm` and `shift_kind` and `shift_amt` have no effect. When `imm_sel` is 0, `b_eff` is the shifted `src_b`.
- R7: Shift kind 0 passes `src_b` unchanged for every value of `shift_amt`.
- R8: Shift kind 1 shifts `src_b` left by `shift_amt` and fills the vacated low bits with zeros.
- R9: Shift kind 2 shifts `src_b` right by `shift_amt` and fills the vacated high bits with zeros.
- R10: Shift kind 3 shifts `src_b` right by `shift_amt` and fills the vacated high bits with bit 15 of `src_b`.
- R11: `equal` is 1 exactly when `src_a` equals the unshifted `src_b`. This holds whatever the opcode, shift fields or `imm_sel` are.
- R12: Opcodes 13 and 14 (the branches) give `src_a - b_eff`. Opcode 15 (the jump) gives `b_eff`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 4 | Operation code |
| imm_sel | input | 1 | 1 selects the immediate as the second operand |
| src_a | input | 16 | First operand |
| src_b | input | 16 | Second register operand |
| imm | input | 16 | Immediate operand |
| shift_kind | input | 2 | 0 none, 1 left, 2 logical right, 3 arithmetic right |
| shift_amt | input | 4 | Shift distance |
| result | output | 16 | Operation result or memory address |
| equal | output | 1 | `src_a` equals `src_b` |

## Verification
The bench builds the unit with its default 16-bit data width, so the shift amount field is 4 bits wide. At that width every shift distance from 0 to 15 can be reached, and so can the sign boundary at 16'h8000. Directed vectors cover these cases:
- an arithmetic shift of a negative value by 15;
- the signed and unsigned compares on the same bit patterns;
- a shift of kind 0 with a nonzero amount;
- immediate form with shift fields set that must be ignored.

A long run of pseudo-random vectors covers all sixteen opcodes.

// File: rtl/exec_pkg.sv
`timescale 1ns/1ps
package exec_pkg;
  localparam int DATA_W  = 16;
  localparam int OP_W    = 4;
  localparam int KIND_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_NAND = 4'd4,
    OP_NOR  = 4'd5,
    OP_XOR  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_LDB  = 4'd9,
    OP_LDW  = 4'd10,
    OP_STB  = 4'd11,
    OP_STW  = 4'd12,
    OP_BREQ = 4'd13,
    OP_BRNE = 4'd14,
    OP_JMP  = 4'd15
  } alu_op_e;

  typedef enum logic [KIND_W-1:0] {
    SH_NONE = 2'd0,
    SH_LEFT = 2'd1,
    SH_LSR  = 2'd2,
    SH_ASR  = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/operand_shifter.sv
`timescale 1ns/1ps
module operand_shifter
  import exec_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [W-1:0]     din,
  input  shift_kind_e      kind,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [AMT_W+1];
  logic         fill;
  logic         go_left;
  logic         active;

  always_comb begin
    active  = (kind != SH_NONE);
    go_left = (kind == SH_LEFT);
    fill    = (kind == SH_ASR) ? din[W-1] : 1'b0;
  end

  assign stage[0] = din;

  // Log shifter: stage s moves the value by 2**s when bit s of amt is set
  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      if (go_left)
        moved = {stage[s][W-1-DIST:0], {DIST{1'b0}}};
      else
        moved = {{DIST{fill}}, stage[s][W-1:DIST]};
      stage[s+1] = (active && amt[s]) ? moved : stage[s];
    end
  end

  assign dout = stage[AMT_W];

  always_comb begin : chk_shift
    // R7
    pass_chk: assert (kind != SH_NONE || dout == din)
      else $error("shift kind none altered operand");
    // R8
    left_zero_chk: assert (!(kind == SH_LEFT && amt != '0) || dout[0] == 1'b0)
      else $error("left shift did not zero-fill");
    // R9
    lsr_zero_chk: assert (!(kind == SH_LSR && amt != '0) || dout[W-1] == 1'b0)
      else $error("logical right shift did not zero-fill");
    // R10
    asr_sign_chk: assert (kind != SH_ASR || dout[W-1] == din[W-1])
      else $error("arithmetic shift lost sign");
  end
endmodule

// File: rtl/operand_select.sv
`timescale 1ns/1ps
module operand_select
  import exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic         use_imm,
  input  logic [W-1:0] shifted,
  input  logic [W-1:0] imm,
  output logic [W-1:0] b_eff
);
  always_comb begin
    b_eff = use_imm ? imm : shifted;
  end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import exec_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  logic [W-1:0] sum;
  logic [W-1:0] diff;
  logic         lt_s;
  logic         lt_u;

  always_comb begin
    sum  = a + b;
    diff = a - b;
    lt_s = $signed(a) < $signed(b);
    lt_u = a < b;
  end

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum;
      OP_SUB:  y = diff;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_NAND: y = ~(a & b);
      OP_NOR:  y = ~(a | b);
      OP_XOR:  y = a ^ b;
      OP_SLT:  y = {{(W-1){1'b0}}, lt_s};
      OP_SLTU: y = {{(W-1){1'b0}}, lt_u};
      OP_LDB, OP_LDW, OP_STB, OP_STW: y = sum;
      OP_BREQ, OP_BRNE: y = diff;
      OP_JMP:  y = b;
      default: y = '0;
    endcase
  end

  always_comb begin : chk_alu
    // R3
    slt_bool_chk: assert (op != OP_SLT || y[W-1:1] == '0)
      else $error("signed compare not boolean");
    // R4
    sltu_bool_chk: assert (op != OP_SLTU || y[W-1:1] == '0)
      else $error("unsigned compare not boolean");
  end
endmodule

// File: rtl/shifted_alu_exec.sv
`timescale 1ns/1ps
module shifted_alu_exec
  import exec_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int AMT_W = $clog2(W)
) (
  input  logic [OP_W-1:0]   opcode,
  input  logic              imm_sel,
  input  logic [W-1:0]      src_a,
  input  logic [W-1:0]      src_b,
  input  logic [W-1:0]      imm,
  input  logic [KIND_W-1:0] shift_kind,
  input  logic [AMT_W-1:0]  shift_amt,
  output logic [W-1:0]      result,
  output logic              equal
);
  logic [W-1:0] b_shifted;
  logic [W-1:0] b_eff;

  operand_shifter #(.W(W), .AMT_W(AMT_W)) u_shift (
    .din  (src_b),
    .kind (shift_kind_e'(shift_kind)),
    .amt  (shift_amt),
    .dout (b_shifted)
  );

  operand_select #(.W(W)) u_sel (
    .use_imm (imm_sel),
    .shifted (b_shifted),
    .imm     (imm),
    .b_eff   (b_eff)
  );

  alu_core #(.W(W)) u_alu (
    .op (alu_op_e'(opcode)),
    .a  (src_a),
    .b  (b_eff),
    .y  (result)
  );

  always_comb begin
    equal = (src_a == src_b);
  end

  always_comb begin : chk_top
    // R6
    imm_route_chk: assert (!imm_sel || b_eff == imm)
      else $error("immediate not routed to operand");
    // R11
    eq_sub_chk: assert (!(opcode == OP_SUB && !imm_sel && shift_kind == SH_NONE)
                        || (equal == (result == '0)))
      else $error("equality flag disagrees with difference");
  end
endmodule

// File: tb/shifted_alu_exec_test.sv
`timescale 1ns/1ps
module shifted_alu_exec_test;
  localparam int W = 16;

  typedef struct {
    logic [W-1:0] res;
    logic         eq;
    string        tag;
  } exp_t;

  logic         clk;
  logic         rst_n;
  logic [3:0]   opcode;
  logic         imm_sel;
  logic [W-1:0] src_a, src_b, imm;
  logic [1:0]   shift_kind;
  logic [3:0]   shift_amt;
  logic [W-1:0] result;
  logic         equal;

  exp_t q[$];
  int   n_vec;
  int   n_bad;
  bit   done;

  shifted_alu_exec uut (
    .opcode(opcode), .imm_sel(imm_sel), .src_a(src_a), .src_b(src_b),
    .imm(imm), .shift_kind(shift_kind), .shift_amt(shift_amt),
    .result(result), .equal(equal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [W-1:0] model(input logic [3:0] op, input logic isimm,
      input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] im,
      input logic [1:0] k, input logic [3:0] n);
    logic [W-1:0] bb;
    if (isimm) bb = im;
    else case (k)
      2'd0: bb = b;
      2'd1: bb = b << n;
      2'd2: bb = b >> n;
      default: bb = W'($signed(b) >>> n);
    endcase
    case (op)
      4'd0: return a + bb;
      4'd1: return a - bb;
      4'd2: return a & bb;
      4'd3: return a | bb;
      4'd4: return ~(a & bb);
      4'd5: return ~(a | bb);
      4'd6: return a ^ bb;
      4'd7: return ($signed(a) < $signed(bb)) ? 16'h0001 : 16'h0000;
      4'd8: return (a < bb) ? 16'h0001 : 16'h0000;
      4'd9, 4'd10, 4'd11, 4'd12: return a + bb;
      4'd13, 4'd14: return a - bb;
      default: return bb;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1: return "R1";
      4'd2, 4'd3, 4'd4, 4'd5, 4'd6: return "R2";
      4'd7: return "R3";
      4'd8: return "R4";
      4'd9, 4'd10, 4'd11, 4'd12: return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic apply(input logic [3:0] op, input logic isimm, input logic [W-1:0] a,
      input logic [W-1:0] b, input logic [W-1:0] im, input logic [1:0] k,
      input logic [3:0] n, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    opcode = op; imm_sel = isimm; src_a = a; src_b = b; imm = im;
    shift_kind = k; shift_amt = n;
    e.res = model(op, isimm, a, b, im, k, n);
    e.eq  = (a == b);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares away from the rising edge
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (result !== e.res || equal !== e.eq) begin
        n_bad++;
        $display("FAIL %s: result=%h equal=%b expected result=%h equal=%b",
                 e.tag, result, equal, e.res, e.eq);
      end
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    opcode = '0; imm_sel = 0; src_a = '0; src_b = '0; imm = '0;
    shift_kind = '0; shift_amt = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    // reset-state vector: all zero inputs
    apply(4'd0, 0, 16'h0000, 16'h0000, 16'h0000, 2'd0, 4'd0, "R1 R11 reset");
    // R1 wrap-around
    apply(4'd0, 0, 16'hFFFF, 16'h0001, 16'h0, 2'd0, 4'd0, "R1 add wrap");
    apply(4'd1, 0, 16'h0000, 16'h0001, 16'h0, 2'd0, 4'd0, "R1 sub wrap");
    // R2 bitwise
    apply(4'd2, 0, 16'hF0F0, 16'hFF00, 16'h0, 2'd0, 4'd0, "R2 and");
    apply(4'd3, 0, 16'hF0F0, 16'h0F00, 16'h0, 2'd0, 4'd0, "R2 or");
    apply(4'd4, 0, 16'hF0F0, 16'hFF00, 16'h0, 2'd0, 4'd0, "R2 nand");
    apply(4'd5, 0, 16'hF0F0, 16'h0F00, 16'h0, 2'd0, 4'd0, "R2 nor");
    apply(4'd6, 0, 16'hAAAA, 16'hFFFF, 16'h0, 2'd0, 4'd0, "R2 xor");
    // R3 / R4 on the same patterns
    apply(4'd7, 0, 16'hFFFF, 16'h0001, 16'h0, 2'd0, 4'd0, "R3 -1<1 true");
    apply(4'd8, 0, 16'hFFFF, 16'h0001, 16'h0, 2'd0, 4'd0, "R4 ffff<1 false");
    apply(4'd7, 0, 16'h7FFF, 16'h8000, 16'h0, 2'd0, 4'd0, "R3 max<min false");
    apply(4'd8, 0, 16'h7FFF, 16'h8000, 16'h0, 2'd0, 4'd0, "R4 7fff<8000 true");
    apply(4'd7, 0, 16'h0005, 16'h0005, 16'h0, 2'd0, 4'd0, "R3 equal false");
    // R5 addresses
    apply(4'd9,  1, 16'h1000, 16'h0, 16'h0034, 2'd0, 4'd0, "R5 lb addr");
    apply(4'd12, 0, 16'h2000, 16'h0003, 16'h0, 2'd1, 4'd4, "R5 sw addr shifted");
    // R6 immediate ignores shift fields
    apply(4'd0, 1, 16'h0001, 16'h1234, 16'h8001, 2'd3, 4'd15, "R6 imm no shift");
    apply(4'd15, 1, 16'h0, 16'h0, 16'hBEEF, 2'd1, 4'd3, "R6 imm jump");
    // R7 kind none with nonzero amount
    apply(4'd15, 0, 16'h0, 16'h8421, 16'h0, 2'd0, 4'd7, "R7 pass amt7");
    apply(4'd15, 0, 16'h0, 16'hC001, 16'h0, 2'd0, 4'd15, "R7 pass amt15");
    // R8..R10 shifts
    apply(4'd15, 0, 16'h0, 16'h8001, 16'h0, 2'd1, 4'd1, "R8 left 1");
    apply(4'd15, 0, 16'h0, 16'h0001, 16'h0, 2'd1, 4'd15, "R8 left 15");
    apply(4'd15, 0, 16'h0, 16'h8000, 16'h0, 2'd2, 4'd15, "R9 lsr 15");
    apply(4'd15, 0, 16'h0, 16'hF0F0, 16'h0, 2'd2, 4'd4, "R9 lsr 4");
    apply(4'd15, 0, 16'h0, 16'h8000, 16'h0, 2'd3, 4'd15, "R10 asr neg 15");
    apply(4'd15, 0, 16'h0, 16'h7000, 16'h0, 2'd3, 4'd3, "R10 asr pos");
    apply(4'd15, 0, 16'h0, 16'h9234, 16'h0, 2'd3, 4'd0, "R10 asr 0");
    // R11 equality on unshifted operands
    apply(4'd0, 0, 16'h0010, 16'h0010, 16'h0, 2'd1, 4'd2, "R11 eq shifted");
    apply(4'd2, 1, 16'h5555, 16'h5555, 16'h1111, 2'd0, 4'd0, "R11 eq imm");
    apply(4'd13, 0, 16'h5555, 16'h5554, 16'h0, 2'd0, 4'd0, "R11 R12 ne");
    // R12 branches and jump
    apply(4'd14, 0, 16'h0100, 16'h0001, 16'h0, 2'd1, 4'd8, "R12 bne diff");
    // random sweep
    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      apply(op, 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            2'($urandom), 4'($urandom), tag_of(op));
    end
    // one random pair with forced equality
    apply(4'd1, 0, 16'h3C3C, 16'h3C3C, 16'h0, 2'd0, 4'd9, "R11 R1 sub self");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule